// File: doc/BRIEF.md
# Phase-Staggered Sixteen-Channel PWM Bank with Double-Buffered Compares

The bank drives sixteen pulse-width outputs from one shared free-running 12-bit count. Each channel holds a rise point and a fall point within the 4096-count period. Its output goes high at the rise point and low at the fall point, and a pulse may wrap across the end of the count. A stagger option advances each channel's whole timing window by a fixed per-channel phase. Edges that would otherwise land together are spread around the period, and no pulse width changes.

Software loads compare values one byte at a time through a write port. The bytes land in shadow copies, which a read port can return. A separate protocol engine supplies two one-cycle strobes: one for the end of a bus transaction and one for a byte acknowledge. A mode bit picks which strobe commits the shadow copies. A committed channel does not switch at once. It waits for the last count of its own period, so every period is built from old values only or from new values only.

Each channel runs a small controller with three states. **Idle** means no byte has been written since the last update. **Collect** means some bytes are waiting. **Armed** means a commit was accepted and the channel waits for its boundary. The transitions are:
- *load*: Idle to Collect, on any byte write.
- *commit*: Collect to Armed, on the selected strobe.
- *swap*: Armed to Idle at the boundary, or Armed to Collect if a byte is written in that same cycle.

Top module: `phased_pwm_bank`

## Requirements
- R1: The shared count advances by one each clock and wraps from 4095 to 0, so every channel's waveform repeats every 4096 clocks.
- R2: With distinct active rise point A and fall point B (after any phase shift), an output is high in the clock after the count equals A and low in the clock after it equals B. Each period it is high for (B−A) mod 4096 clocks, including when B is below A.
- R3: When a channel's active rise and fall points are equal, its output stays low for the whole period.
- R4: With stagger enabled, channel n's rise and fall points are both moved later by n×256 counts modulo 4096. Channels with identical settings therefore rise 256·n clocks apart, and never two in one clock.
- R5: Stagger leaves every channel's high time per period unchanged.
- R6: Write and read addresses are 7 bits. Addresses below 0x40 are {channel[3:0], byte[1:0]}, where byte 0 is rise low, 1 is rise high, 2 is fall low and 3 is fall high. High bytes keep only data bits 3:0 and read back with bits 7:4 at zero. Address 0x40 is the mode byte: bit 0 selects commit on acknowledge, and bit 1 enables stagger. Reads return the shadow or mode contents combinationally.
- R7: With mode bit 0 clear, a transaction-end strobe commits every channel that has any byte written since its last update. The acknowledge strobe is ignored in this mode.
- R8: With mode bit 0 set, an acknowledge strobe commits only channels whose four bytes have all been written since their last update. The transaction-end strobe is ignored in this mode.
- R9: Shadow values never affect an output before a commit. A committed channel copies its shadow values into its active compares at the clock where the count equals its phase base minus one (mod 4096), and its written-byte record then restarts.
- R10: A synchronous active-high reset clears the count, all compares and the mode byte, and drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 7 | Write address (see R6) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 7 | Read address (see R6) |
| rd_data | output | 8 | Read data, combinational |
| bus_stop | input | 1 | One-cycle end-of-transaction strobe |
| bus_ack | input | 1 | One-cycle byte-acknowledge strobe |
| pwm_out | output | 16 | Channel outputs, bit n is channel n |

## Verification
The hardest cases to reach from the ports are the ones where a commit, a byte write and a channel's phase boundary all fall in or near the same period. Acknowledge-mode commits are also hard, because they need all four bytes of a channel and a partially written channel must stay frozen. The stimulus drives directed sequences for this: three of four bytes followed by both strobes, then the missing byte, and wrapping pulses and equal compares under both phase modes. Seeded random rounds then mix random byte writes, mode changes and strobes at random points in the period. A cycle-accurate model in the bench follows every output on every clock.

// File: rtl/phpwm_pkg.sv
package phpwm_pkg;

    // Per-channel update controller states
    typedef enum logic [1:0] {
        SLOT_IDLE    = 2'd0,
        SLOT_COLLECT = 2'd1,
        SLOT_ARMED   = 2'd2
    } slot_state_t;

    // Byte selector codes inside one channel's four-byte window
    localparam logic [1:0] SEL_RISE_LO = 2'd0;
    localparam logic [1:0] SEL_RISE_HI = 2'd1;
    localparam logic [1:0] SEL_FALL_LO = 2'd2;
    localparam logic [1:0] SEL_FALL_HI = 2'd3;

    localparam int BYTE_W  = 8;
    localparam int NBYTES  = 4;

endpackage

// File: rtl/phase_counter.sv
module phase_counter #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R1: wrap from the top count to zero
    assert_cnt_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX) |=> (cnt == '0));

    // R1: single step otherwise
    assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
        (cnt != CNT_MAX) |=> (cnt == $past(cnt) + CW'(1)));

endmodule

// File: rtl/pwm_slot.sv
module pwm_slot
    import phpwm_pkg::*;
#(
    parameter int CW  = 12,
    parameter int NCH = 16,
    parameter int IDX = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt,
    input  logic          stagger_en,
    input  logic          ack_mode,
    input  logic          bus_stop,
    input  logic          bus_ack,
    input  logic          wr_hit,
    input  logic [1:0]    wr_sel,
    input  logic [7:0]    wr_data,
    output logic [CW-1:0] sh_rise,
    output logic [CW-1:0] sh_fall,
    output logic          pwm
);

    localparam int            HIW  = CW - BYTE_W;
    localparam int            STEP = (1 << CW) / NCH;
    localparam logic [CW-1:0] OFS  = CW'(IDX * STEP);
    localparam logic [NBYTES-1:0] ALL_BYTES = {NBYTES{1'b1}};

    slot_state_t       st, st_d;
    logic [NBYTES-1:0] mask, wbit;
    logic [CW-1:0]     rise_act, fall_act;
    logic [CW-1:0]     base, last, rise_eff, fall_eff;
    logic              commit_ok, swap, pwm_d;

    // Phase arithmetic: window shift and the channel's boundary count
    always_comb begin
        base     = stagger_en ? OFS : '0;
        last     = base - CW'(1);
        rise_eff = rise_act + base;
        fall_eff = fall_act + base;
    end

    // Event decode
    always_comb begin
        wbit      = wr_hit ? (NBYTES'(1) << wr_sel) : '0;
        commit_ok = ack_mode ? (bus_ack && (mask == ALL_BYTES))
                             : (bus_stop && (mask != '0));
        swap      = (st == SLOT_ARMED) && (cnt == last);
    end

    // Next-state logic
    always_comb begin
        st_d = st;
        unique case (st)
            SLOT_IDLE: begin
                if (wr_hit) st_d = SLOT_COLLECT;        // load
            end
            SLOT_COLLECT: begin
                if (commit_ok) st_d = SLOT_ARMED;       // commit
            end
            SLOT_ARMED: begin
                if (swap) st_d = wr_hit ? SLOT_COLLECT : SLOT_IDLE;  // swap
            end
            default: st_d = SLOT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) st <= SLOT_IDLE;
        else     st <= st_d;
    end

    // Written-byte record
    always_ff @(posedge clk) begin
        if (rst)       mask <= '0;
        else if (swap) mask <= wbit;
        else           mask <= mask | wbit;
    end

    // Shadow compares
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_rise <= '0;
            sh_fall <= '0;
        end else if (wr_hit) begin
            unique case (wr_sel)
                SEL_RISE_LO: sh_rise[BYTE_W-1:0]  <= wr_data;
                SEL_RISE_HI: sh_rise[CW-1:BYTE_W] <= wr_data[HIW-1:0];
                SEL_FALL_LO: sh_fall[BYTE_W-1:0]  <= wr_data;
                SEL_FALL_HI: sh_fall[CW-1:BYTE_W] <= wr_data[HIW-1:0];
                default: ;
            endcase
        end
    end

    // Active compares, swapped only at the boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            rise_act <= '0;
            fall_act <= '0;
        end else if (swap) begin
            rise_act <= sh_rise;
            fall_act <= sh_fall;
        end
    end

    // Output process
    always_comb begin
        if (rise_eff == fall_eff)  pwm_d = 1'b0;
        else if (cnt == rise_eff)  pwm_d = 1'b1;
        else if (cnt == fall_eff)  pwm_d = 1'b0;
        else                       pwm_d = pwm;
    end

    always_ff @(posedge clk) begin
        if (rst) pwm <= 1'b0;
        else     pwm <= pwm_d;
    end

    // R3: equal compares give a low output
    assert_eq_low_R3: assert property (@(posedge clk) disable iff (rst)
        (rise_eff == fall_eff) |=> !pwm);

    // R2: rise and fall one clock after the matching count
    assert_rise_R2: assert property (@(posedge clk) disable iff (rst)
        ((rise_eff != fall_eff) && (cnt == rise_eff)) |=> pwm);

    assert_fall_R2: assert property (@(posedge clk) disable iff (rst)
        ((rise_eff != fall_eff) && (cnt == fall_eff)) |=> !pwm);

    // R9: swap at the boundary copies the shadow values
    assert_swap_R9: assert property (@(posedge clk) disable iff (rst)
        ((st == SLOT_ARMED) && (cnt == last)) |=>
        ((st != SLOT_ARMED) && (rise_act == $past(sh_rise)) && (fall_act == $past(sh_fall))));

    // R9: active compares frozen unless armed
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (st != SLOT_ARMED) |=> ($stable(rise_act) && $stable(fall_act)));

    // R8: partial channel never arms in acknowledge mode
    assert_partial_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_mode && (st == SLOT_COLLECT) && (mask != ALL_BYTES)) |=> (st != SLOT_ARMED));

    // R7: transaction end arms a pending channel in stop mode
    assert_stop_arms_R7: assert property (@(posedge clk) disable iff (rst)
        (!ack_mode && (st == SLOT_COLLECT) && bus_stop) |=> (st == SLOT_ARMED));

endmodule

// File: rtl/phased_pwm_bank.sv
module phased_pwm_bank
    import phpwm_pkg::*;
#(
    parameter  int NCH = 16,
    parameter  int CW  = 12,
    localparam int AW  = $clog2(NCH) + 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [7:0]     wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [7:0]     rd_data,
    input  logic           bus_stop,
    input  logic           bus_ack,
    output logic [NCH-1:0] pwm_out
);

    localparam int CHW = $clog2(NCH);

    logic [CW-1:0]  cnt;
    logic           ack_mode, stagger_en;
    logic           mode_hit;
    logic [CHW-1:0] wr_ch, rd_ch;
    logic [1:0]     wr_sel, rd_sel;
    logic [CW-1:0]  sh_rise [NCH];
    logic [CW-1:0]  sh_fall [NCH];

    phase_counter #(.CW(CW)) u_cnt (
        .clk (clk),
        .rst (rst),
        .cnt (cnt)
    );

    // Address decode
    always_comb begin
        mode_hit = wr_en && wr_addr[AW-1];
        wr_ch    = wr_addr[AW-2:2];
        wr_sel   = wr_addr[1:0];
        rd_ch    = rd_addr[AW-2:2];
        rd_sel   = rd_addr[1:0];
    end

    // Mode byte
    always_ff @(posedge clk) begin
        if (rst) begin
            ack_mode   <= 1'b0;
            stagger_en <= 1'b0;
        end else if (mode_hit) begin
            ack_mode   <= wr_data[0];
            stagger_en <= wr_data[1];
        end
    end

    generate
        for (genvar gi = 0; gi < NCH; gi++) begin : g_slot
            logic hit;
            assign hit = wr_en && !wr_addr[AW-1] && (wr_ch == CHW'(gi));
            pwm_slot #(.CW(CW), .NCH(NCH), .IDX(gi)) u_slot (
                .clk        (clk),
                .rst        (rst),
                .cnt        (cnt),
                .stagger_en (stagger_en),
                .ack_mode   (ack_mode),
                .bus_stop   (bus_stop),
                .bus_ack    (bus_ack),
                .wr_hit     (hit),
                .wr_sel     (wr_sel),
                .wr_data    (wr_data),
                .sh_rise    (sh_rise[gi]),
                .sh_fall    (sh_fall[gi]),
                .pwm        (pwm_out[gi])
            );
        end
    endgenerate

    // Read mux
    always_comb begin
        if (rd_addr[AW-1]) begin
            rd_data = {6'b0, stagger_en, ack_mode};
        end else begin
            unique case (rd_sel)
                SEL_RISE_LO: rd_data = sh_rise[rd_ch][BYTE_W-1:0];
                SEL_RISE_HI: rd_data = 8'(sh_rise[rd_ch] >> BYTE_W);
                SEL_FALL_LO: rd_data = sh_fall[rd_ch][BYTE_W-1:0];
                SEL_FALL_HI: rd_data = 8'(sh_fall[rd_ch] >> BYTE_W);
                default:     rd_data = '0;
            endcase
        end
    end

    // R6: mode byte reflects the last mode write
    assert_mode_wr_R6: assert property (@(posedge clk) disable iff (rst)
        mode_hit |=> ((ack_mode == $past(wr_data[0])) && (stagger_en == $past(wr_data[1]))));

endmodule

// File: tb/phased_pwm_bank_bench.sv
module phased_pwm_bank_bench;

    localparam int NCH = 16;
    localparam int PER = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [6:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        bus_stop = 1'b0;
    logic        bus_ack = 1'b0;
    logic [15:0] pwm_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    phased_pwm_bank u_phased_pwm_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .bus_stop(bus_stop), .bus_ack(bus_ack),
        .pwm_out(pwm_out));

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- reference model (from requirements) ----------------
    logic [11:0] m_ra [NCH];
    logic [11:0] m_fa [NCH];
    logic [11:0] m_rs [NCH];
    logic [11:0] m_fs [NCH];
    logic [3:0]  m_mask [NCH];
    logic        m_arm [NCH];
    logic [15:0] m_out;
    logic [11:0] m_cnt;
    logic        m_ack, m_stg;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0; m_out <= '0; m_ack <= 1'b0; m_stg <= 1'b0;
            for (int i = 0; i < NCH; i++) begin
                m_ra[i] <= '0; m_fa[i] <= '0; m_rs[i] <= '0; m_fs[i] <= '0;
                m_mask[i] <= '0; m_arm[i] <= 1'b0;
            end
        end else begin
            for (int i = 0; i < NCH; i++) begin
                logic [11:0] b, re, fe;
                logic [3:0]  wb;
                b  = m_stg ? 12'(i * 256) : 12'd0;
                re = m_ra[i] + b;
                fe = m_fa[i] + b;
                if (re == fe)         m_out[i] <= 1'b0;
                else if (m_cnt == re) m_out[i] <= 1'b1;
                else if (m_cnt == fe) m_out[i] <= 1'b0;
                wb = (wr_en && !wr_addr[6] && wr_addr[5:2] == 4'(i)) ? (4'b1 << wr_addr[1:0]) : 4'b0;
                if (m_arm[i] && m_cnt == b - 12'd1) begin
                    m_ra[i] <= m_rs[i]; m_fa[i] <= m_fs[i];
                    m_arm[i] <= 1'b0; m_mask[i] <= wb;
                end else begin
                    m_mask[i] <= m_mask[i] | wb;
                    if (!m_arm[i] && (m_ack ? (bus_ack && m_mask[i] == 4'hF)
                                            : (bus_stop && m_mask[i] != 4'h0)))
                        m_arm[i] <= 1'b1;
                end
                if (wb[0]) m_rs[i][7:0]  <= wr_data;
                if (wb[1]) m_rs[i][11:8] <= wr_data[3:0];
                if (wb[2]) m_fs[i][7:0]  <= wr_data;
                if (wb[3]) m_fs[i][11:8] <= wr_data[3:0];
            end
            m_cnt <= m_cnt + 12'd1;
            if (wr_en && wr_addr[6]) begin m_ack <= wr_data[0]; m_stg <= wr_data[1]; end
        end
    end

    // ---------------- monitors ----------------
    int mism = 0;
    logic [15:0] mis_act, mis_exp;
    bit cap = 0;
    int hi_cnt [NCH];
    int rise_a [NCH];
    int rise_b [NCH];
    int multi = 0;
    logic [15:0] prev = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (pwm_out !== m_out) begin
                if (mism == 0) begin mis_act = pwm_out; mis_exp = m_out; end
                mism++;
            end
            if (cap) begin
                if ($countones(pwm_out & ~prev) > 1) multi++;
                for (int i = 0; i < NCH; i++) begin
                    if (pwm_out[i]) hi_cnt[i]++;
                    if (pwm_out[i] && !prev[i]) begin rise_a[i] = rise_b[i]; rise_b[i] = cyc; end
                end
            end
        end
        prev = pwm_out;
    end

    // ---------------- tasks ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic window(input string req);
        total++;
        if (mism != 0) begin
            bad++;
            $display("FAIL %s model mismatch count=%0d actual=%h expected=%h", req, mism, mis_act, mis_exp);
        end
        mism = 0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int n);
        @(negedge clk);
        for (int i = 0; i < NCH; i++) begin hi_cnt[i] = 0; rise_a[i] = -1; rise_b[i] = -1; end
        multi = 0;
        cap = 1;
        run(n);
        cap = 0;
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_ch(input int ch, input int r, input int f);
        wr({1'b0, 4'(ch), 2'd0}, 8'(r));
        wr({1'b0, 4'(ch), 2'd1}, 8'(r >> 8));
        wr({1'b0, 4'(ch), 2'd2}, 8'(f));
        wr({1'b0, 4'(ch), 2'd3}, 8'(f >> 8));
    endtask

    task automatic pulse(input bit is_ack);
        @(negedge clk);
        if (is_ack) bus_ack = 1'b1; else bus_stop = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0; bus_stop = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    function automatic int duty(input int r, input int f);
        return (r == f) ? 0 : ((f - r) % PER + PER) % PER;
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        check(pwm_out == 16'h0, "R10 outputs low", int'(pwm_out), 0);
        rd(7'h40, d); check(d == 8'h00, "R10 mode cleared", int'(d), 0);
        rd(7'h05, d); check(d == 8'h00, "R10 shadow cleared", int'(d), 0);

        // R6 readback
        wr(7'h0D, 8'hFF); rd(7'h0D, d); check(d == 8'h0F, "R6 high byte masked", int'(d), 15);
        wr(7'h0C, 8'hA5); rd(7'h0C, d); check(d == 8'hA5, "R6 low byte", int'(d), 165);
        wr(7'h40, 8'h03); rd(7'h40, d); check(d == 8'h03, "R6 mode byte", int'(d), 3);
        wr(7'h40, 8'h00);

        // Directed stop-mode set
        for (int i = 0; i < NCH; i++) begin
            case (i)
                0: wr_ch(0, 10, 20);
                1: wr_ch(1, 4000, 50);
                2: wr_ch(2, 300, 300);
                5: wr_ch(5, 0, 0);
                default: wr_ch(i, $urandom_range(4095), $urandom_range(4095));
            endcase
        end
        pulse(1'b1);                       // acknowledge ignored in stop mode
        measure(PER);
        check(hi_cnt[0] == 0, "R7 ack ignored, ch0 unchanged", hi_cnt[0], 0);
        check(pwm_out == 16'h0, "R9 no output before commit", int'(pwm_out), 0);
        window("R9 pre-commit");
        pulse(1'b0);
        run(PER);
        measure(PER);
        check(hi_cnt[0] == 10, "R2 ch0 duty", hi_cnt[0], 10);
        check(hi_cnt[1] == duty(4000, 50), "R2 wrapping duty", hi_cnt[1], duty(4000, 50));
        check(hi_cnt[2] == 0, "R3 equal compares low", hi_cnt[2], 0);
        measure(2 * PER + 8);
        check(rise_b[0] - rise_a[0] == PER, "R1 period", rise_b[0] - rise_a[0], PER);
        window("R7 stop commit");

        // Acknowledge mode, partial channel
        wr(7'h40, 8'h01);
        wr({1'b0, 4'd5, 2'd0}, 8'd100);
        wr({1'b0, 4'd5, 2'd1}, 8'd0);
        wr({1'b0, 4'd5, 2'd2}, 8'h40);
        pulse(1'b1);
        pulse(1'b0);
        run(PER + 100);
        measure(PER);
        check(hi_cnt[5] == 0, "R8 partial channel frozen", hi_cnt[5], 0);
        wr({1'b0, 4'd5, 2'd3}, 8'h02);
        rd({1'b0, 4'd5, 2'd3}, d); check(d == 8'h02, "R6 fall high readback", int'(d), 2);
        pulse(1'b1);
        run(PER);
        measure(PER);
        check(hi_cnt[5] == 476, "R8 full channel applied", hi_cnt[5], 476);
        window("R8 ack mode");

        // Stagger
        wr(7'h40, 8'h03);
        for (int i = 0; i < NCH; i++) wr_ch(i, 0, 128);
        pulse(1'b1);
        run(2 * PER);
        measure(PER);
        for (int i = 0; i < NCH; i++)
            check(hi_cnt[i] == 128, $sformatf("R5 duty ch%0d", i), hi_cnt[i], 128);
        check(multi == 0, "R4 no coincident rises", multi, 0);
        for (int i = 1; i < NCH; i++)
            check((((rise_b[i] - rise_b[0]) % PER) + PER) % PER == i * 256,
                  $sformatf("R4 phase ch%0d", i),
                  (((rise_b[i] - rise_b[0]) % PER) + PER) % PER, i * 256);
        window("R4 stagger model");

        // Random rounds
        for (int k = 0; k < 6; k++) begin
            wr(7'h40, 8'($urandom_range(3)));
            for (int j = 0; j < int'($urandom_range(30, 1)); j++)
                wr({1'b0, 6'($urandom_range(63))}, 8'($urandom));
            wr_ch($urandom_range(15), $urandom_range(4095), $urandom_range(4095));
            pulse(1'($urandom_range(1)));
            run($urandom_range(500, 3000));
            pulse(1'($urandom_range(1)));
            run($urandom_range(1000, 5000));
            window("R7 R8 R9 random round");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule